// File: doc/BRIEF.md
# Trapping Integer Add/Subtract Unit

This block is a 32-bit integer add/subtract stage with one register of latency. Each valid operation takes a 3-bit opcode, two register operands, a 16-bit immediate and the address of the instruction. It produces a registered result with a write-enable for the destination register. Subtraction is done by inverting the second operand and adding with a carry-in of one. The sum comes from a grouped carry-lookahead adder.

The opcode decides how signed overflow is treated. The trapping forms (add, add-immediate, subtract) turn overflow into a one-cycle exception pulse. On that pulse the unit withholds the register write, records the faulting instruction address in the exception PC, and drives a fixed handler address on the redirect output. The non-trapping forms keep the wrapped result and never raise the pulse. A move-from-exception-PC opcode returns the saved address as an ordinary result, so that software can later return to the faulting instruction.

Top module: `trap_alu`

## Requirements
- R1: Opcodes are encoded as follows: 0 = add, 1 = add-unsigned, 2 = add-imm, 3 = add-imm-unsigned, 4 = sub, 5 = sub-unsigned, 6 = read-EPC and 7 = no-op. A valid operation presented on a rising edge appears on the outputs after that edge, with `res_valid_o` high. For opcodes 0 to 5 the result is the modulo-2^32 sum or difference.
- R2: Subtraction adds the two's-complement negation of the second operand. 7 − 6 gives 1, and 7 + 0xFFFFFFFA gives 1.
- R3: An addition whose two operands have different sign bits never signals overflow.
- R4: A subtraction whose operands have the same sign bit never signals overflow. A subtraction overflows when a non-negative value minus a negative value gives a negative result, or when a negative value minus a non-negative value gives a non-negative result.
- R5: On signed overflow, opcodes 0, 2 and 4 raise `trap_o` for exactly one cycle, in the same cycle as their result.
- R6: Opcodes 1, 3 and 5 never raise `trap_o`. They write the wrapped result with `wr_en_o` high.
- R7: When `trap_o` is high, `wr_en_o` is low, so no result is committed.
- R8: On a trap, `epc_o` takes the instruction address of the faulting operation in the same cycle. `redirect_pc_o` equals the HANDLER_ADDR parameter (default 0x80000180) while `trap_o` is high and is 0 otherwise.
- R9: Opcode 6 returns the current EPC value on `res_data_o` with `wr_en_o` high. Opcode 7 gives result 0 with `wr_en_o` low.
- R10: Opcodes 2 and 3 use the 16-bit immediate sign-extended to 32 bits in place of `src_b_i`, and `src_b_i` has no effect on them.
- R11: After reset, all outputs are 0 and the EPC is 0.
- R12: A cycle without `in_valid_i` gives `res_valid_o`, `wr_en_o` and `trap_o` low, leaves the EPC unchanged, and holds `res_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode (see R1) |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate for the immediate forms |
| in_pc_i | input | 32 | Address of the instruction |
| res_valid_o | output | 1 | Registered result valid |
| res_data_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write-enable |
| trap_o | output | 1 | Overflow exception pulse |
| redirect_pc_o | output | 32 | Handler target while trapping |
| epc_o | output | 32 | Exception PC |

## Verification
Some properties are checked on every cycle. The sign-based overflow rule must agree with the adder's carry into and out of the top bit. Mixed-sign additions and same-sign subtractions must never flag overflow. Unsigned opcodes must never trap. A trap must block the write, load the EPC with the previous cycle's address and present the handler target. Idle cycles must leave the outputs quiet and the EPC stable.

Other behaviour can only be shown by the bench's scenarios, which are compared against an integer reference model. These cover:
- the exact wrapped values;
- the boundary overflows at 0x7FFFFFFF and 0x80000000;
- sign extension of the immediate;
- reading the EPC back after a trap.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADDU  = 3'd1,
    OP_ADDI  = 3'd2,
    OP_ADDIU = 3'd3,
    OP_SUB   = 3'd4,
    OP_SUBU  = 3'd5,
    OP_MFEPC = 3'd6,
    OP_NOP   = 3'd7
  } alu_op_e;

  function automatic logic op_traps(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDI) || (op == OP_SUB);
  endfunction

  function automatic logic op_quiet(alu_op_e op);
    return (op == OP_ADDU) || (op == OP_ADDIU) || (op == OP_SUBU);
  endfunction

  function automatic logic op_is_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SUBU);
  endfunction

  function automatic logic op_uses_imm(alu_op_e op);
    return (op == OP_ADDI) || (op == OP_ADDIU);
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return op_traps(op) || op_quiet(op);
  endfunction

  // Overflow judged from sign bits only, on the original operands.
  function automatic logic sign_overflow(logic a_s, logic b_s, logic r_s, logic sub);
    if (sub) return (a_s != b_s) && (r_s != a_s);
    else     return (a_s == b_s) && (r_s != a_s);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import trap_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   src_b,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   opb_raw,
  output logic [DATA_W-1:0]   addend,
  output logic                carry_in
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    opb_raw  = op_uses_imm(op) ? imm_ext : src_b;
    // negate by inversion plus carry-in of one
    addend   = op_is_sub(op) ? ~opb_raw : opb_raw;
    carry_in = op_is_sub(op);
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_msb,
  output logic             c_out
);
  localparam int NGRP = WIDTH / GROUP;

  logic [NGRP:0]  grp_c;
  logic [WIDTH:0] bit_c;

  assign grp_c[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP-1:0] gen, prop;
    logic [GROUP:0]   c;
    assign gen  = a[g*GROUP +: GROUP] & b[g*GROUP +: GROUP];
    assign prop = a[g*GROUP +: GROUP] ^ b[g*GROUP +: GROUP];

    always_comb begin
      logic gacc, pacc;
      gacc = 1'b0;
      pacc = 1'b1;
      c[0] = grp_c[g];
      for (int i = 0; i < GROUP; i++) begin
        gacc     = gen[i] | (prop[i] & gacc);
        pacc     = pacc & prop[i];
        c[i+1]   = gacc | (pacc & grp_c[g]);
      end
    end

    assign bit_c[g*GROUP +: GROUP] = c[GROUP-1:0];
    assign grp_c[g+1]              = c[GROUP];
  end

  assign bit_c[WIDTH] = grp_c[NGRP];
  assign sum   = a ^ b ^ bit_c[WIDTH-1:0];
  assign c_msb = bit_c[WIDTH-1];
  assign c_out = bit_c[WIDTH];
endmodule

// File: rtl/epc_unit.sv
module epc_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] epc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epc <= '0;
    else if (capture) epc <= fault_addr;
  end
endmodule

// File: rtl/trap_alu.sv
module trap_alu
  import trap_alu_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          IMM_W        = 16,
  parameter int          CLA_GROUP    = 4,
  parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] in_pc_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              wr_en_o,
  output logic              trap_o,
  output logic [DATA_W-1:0] redirect_pc_o,
  output logic [DATA_W-1:0] epc_o
);
  localparam int MSB = DATA_W - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DATA_W-1:0] opb_raw, addend, sum;
  logic              carry_in, c_msb, c_out;

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op(op), .src_b(src_b_i), .imm(imm_i),
    .opb_raw(opb_raw), .addend(addend), .carry_in(carry_in)
  );

  cla_adder #(.WIDTH(DATA_W), .GROUP(CLA_GROUP)) u_add (
    .a(src_a_i), .b(addend), .cin(carry_in),
    .sum(sum), .c_msb(c_msb), .c_out(c_out)
  );

  // named internal events for the assertions
  logic ovf_sign, ovf_carry, trap_now, commit_now;
  assign ovf_sign   = sign_overflow(src_a_i[MSB], opb_raw[MSB], sum[MSB], op_is_sub(op));
  assign ovf_carry  = c_msb ^ c_out;
  assign trap_now   = in_valid_i && op_traps(op) && ovf_sign;
  assign commit_now = in_valid_i && (op != OP_NOP) && !trap_now;

  logic [DATA_W-1:0] result_next;
  always_comb begin
    case (op)
      OP_MFEPC: result_next = epc_o;
      OP_NOP:   result_next = '0;
      default:  result_next = sum;
    endcase
  end

  epc_unit #(.ADDR_W(DATA_W)) u_epc (
    .clk(clk), .rst_n(rst_n), .capture(trap_now),
    .fault_addr(in_pc_i), .epc(epc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      wr_en_o     <= 1'b0;
      trap_o      <= 1'b0;
    end else begin
      res_valid_o <= in_valid_i;
      wr_en_o     <= commit_now;
      trap_o      <= trap_now;
      if (in_valid_i) res_data_o <= result_next;
    end
  end

  assign redirect_pc_o = trap_o ? DATA_W'(HANDLER_ADDR) : '0;

  // ---------------- assertions ----------------
  assert_carry_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_is_arith(op)) |-> (ovf_sign == ovf_carry));

  assert_mixed_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_is_arith(op) && !op_is_sub(op) && (src_a_i[MSB] != opb_raw[MSB]))
      |-> !ovf_sign);

  assert_same_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_is_sub(op) && (src_a_i[MSB] == opb_raw[MSB])) |-> !ovf_sign);

  assert_quiet_ops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_quiet(op)) |=> !trap_o);

  assert_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !wr_en_o);

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> res_valid_o);

  assert_epc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (epc_o == $past(in_pc_i)));

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (redirect_pc_o == DATA_W'(HANDLER_ADDR)));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!res_valid_o && !trap_o && !wr_en_o && $stable(epc_o)));

endmodule

// File: tb/trap_alu_test.sv
module trap_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [2:0]  op_i = 3'd7;
  logic [31:0] src_a_i = '0, src_b_i = '0, in_pc_i = '0;
  logic [15:0] imm_i = '0;
  logic        res_valid_o, wr_en_o, trap_o;
  logic [31:0] res_data_o, redirect_pc_o, epc_o;

  localparam logic [31:0] HANDLER = 32'h8000_0180;

  always #2 clk = ~clk;  // 250 MHz

  trap_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i), .in_pc_i(in_pc_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o), .wr_en_o(wr_en_o),
    .trap_o(trap_o), .redirect_pc_o(redirect_pc_o), .epc_o(epc_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_res = '0, m_epc = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic v, logic [2:0] op, logic [31:0] a,
                      logic [31:0] b, logic [15:0] imm, logic [31:0] pc);
    longint sa, sb, r;
    logic [31:0] opb;
    bit ovf, trap, wr;
    in_valid_i = v; op_i = op; src_a_i = a; src_b_i = b; imm_i = imm; in_pc_i = pc;
    opb = (op == 3'd2 || op == 3'd3) ? {{16{imm[15]}}, imm} : b;
    sa  = longint'($signed(a));
    sb  = longint'($signed(opb));
    r   = (op == 3'd4 || op == 3'd5) ? sa - sb : sa + sb;
    ovf = (r > 64'sd2147483647) || (r < -64'sd2147483648);
    trap = v && (op == 3'd0 || op == 3'd2 || op == 3'd4) && ovf;
    wr   = v && (op != 3'd7) && !trap;
    if (v) begin
      if (op == 3'd6)      m_res = m_epc;
      else if (op == 3'd7) m_res = '0;
      else                 m_res = r[31:0];
    end
    if (trap) m_epc = pc;
    @(posedge clk);
    @(negedge clk);
    chk(req, "res_valid", {31'd0, res_valid_o}, {31'd0, v});
    chk(req, "res_data", res_data_o, m_res);
    chk(req, "wr_en", {31'd0, wr_en_o}, {31'd0, wr});
    chk(req, "trap", {31'd0, trap_o}, {31'd0, trap});
    chk(req, "redirect", redirect_pc_o, trap ? HANDLER : 32'd0);
    chk(req, "epc", epc_o, m_epc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "res_valid", {31'd0, res_valid_o}, 32'd0);
    chk("R11", "trap", {31'd0, trap_o}, 32'd0);
    chk("R11", "epc", epc_o, 32'd0);
    chk("R11", "redirect", redirect_pc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R1", 1, 3'd0, 32'd7, 32'd6, 16'h0, 32'h100);                 // 13
    step("R1", 1, 3'd1, 32'hFFFF_FFFF, 32'd2, 16'h0, 32'h104);         // wrap to 1
    step("R2", 1, 3'd4, 32'd7, 32'd6, 16'h0, 32'h108);                 // 1
    step("R2", 1, 3'd0, 32'd7, 32'hFFFF_FFFA, 16'h0, 32'h10C);         // 1
    step("R3", 1, 3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'h110);
    step("R3", 1, 3'd0, 32'hFFFF_FFF6, 32'd4, 16'h0, 32'h114);         // -10+4
    step("R4", 1, 3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 32'h118); // same sign
    step("R4", 1, 3'd4, 32'h8000_0000, 32'd1, 16'h0, 32'h11C);         // neg-pos -> pos
    step("R4", 1, 3'd4, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h120); // pos-neg -> neg
    step("R4", 1, 3'd4, 32'd0, 32'h8000_0000, 16'h0, 32'h124);         // 0 - min
    step("R5", 1, 3'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h128);
    step("R5", 1, 3'd2, 32'h7FFF_FFFF, 32'd0, 16'h0001, 32'h12C);
    step("R7", 1, 3'd1, 32'd1, 32'd1, 16'h0, 32'h130);                 // pulse ended, write back
    step("R6", 1, 3'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h134);
    step("R6", 1, 3'd5, 32'h8000_0000, 32'd1, 16'h0, 32'h138);
    step("R6", 1, 3'd3, 32'h7FFF_FFFF, 32'h0, 16'h7FFF, 32'h13C);
    step("R9", 1, 3'd6, 32'h0, 32'h0, 16'h0, 32'h140);                 // reads 0x12C
    step("R9", 1, 3'd7, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h144);
    step("R10", 1, 3'd2, 32'd10, 32'h1234_5678, 16'hFFFF, 32'h148);    // 9
    step("R10", 1, 3'd3, 32'd0, 32'hDEAD_BEEF, 16'h8000, 32'h14C);     // FFFF8000
    step("R10", 1, 3'd2, 32'h8000_0000, 32'h0, 16'hFFFF, 32'h150);     // trap via imm
    step("R12", 0, 3'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h154);        // idle, no trap
    step("R12", 0, 3'd6, 32'd0, 32'd0, 16'h0, 32'h158);
    step("R8", 1, 3'd6, 32'd0, 32'd0, 16'h0, 32'h15C);                 // EPC still 0x150

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 4 == 0) ra = {ra[31], {31{~ra[31]}}};
      step("R1", ($urandom % 8) != 0, 3'($urandom % 8), ra, rb, 16'($urandom), 32'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule